// File: doc/BRIEF.md
# Latency-Countdown Issue Queue with Ready Precheck

This block holds dispatched instructions until they may issue, without any result-tag broadcast or tag comparators in the entries. Each instruction arrives with a predicted issue latency from an upstream pre-scheduler. The latency is held in a per-entry down-counter. When the counter is zero, the entry looks up the ready bits of its two source registers in a table inside the block. Only an entry whose counter is zero and whose sources are both ready raises a selection request. As a result, an issue port is never spent on an instruction that is only predicted to be ready.

Selection uses a chain of arbitration trees built from four-input cells, one tree per issue port. Each tree grants the oldest request that the trees before it left. Granted entries leave the queue, and the survivors collapse towards slot 0 with their age order unchanged. An entry can be selected from any slot. When an instruction issues, its execution latency is loaded into a countdown for its destination register, and the ready bit of that register is set when the countdown completes. Dispatch clears the ready bit of the new instruction's destination. A full queue stalls dispatch.

Top module: `lat_issue_queue`

## Requirements
- R1: After reset the queue is empty, no port issues, `disp_stall` is low and every register reads as ready.
- R2: An instruction accepted with predicted latency L (L=0..7) is not granted before the L-th cycle after the clock edge that inserted it. It is granted in that cycle if its sources are ready and a port is free.
- R3: An entry whose counter is zero but that has a source not ready is not granted. Its counter stays at zero, and it is granted in the first cycle in which both sources read ready (subject to port limits).
- R4: At most PORTS=4 entries issue per cycle. When more entries are eligible, the oldest ones are granted and the rest stay eligible for the next cycle.
- R5: Port 0 carries the oldest granted entry, port 1 the next oldest, and so on. The valid bits are contiguous from port 0.
- R6: An eligible entry is granted from any slot, ahead of older entries that are not eligible. After a grant the survivors keep their relative age order.
- R7: While the queue holds DEPTH entries, `disp_stall` is high and a dispatch presented in that cycle is dropped (it never issues). The occupancy never exceeds DEPTH.
- R8: When an instruction with execution field X issues in cycle c, its destination reads ready from cycle c+X+1 on. A dependent with latency 0 can therefore issue back-to-back when X=0.
- R9: Accepting a dispatch clears the ready bit of its destination and cancels any countdown pending on that register. The clear wins over a countdown that would complete, or be loaded, in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| disp_valid | input | 1 | Dispatch request |
| disp_tag | input | TAG_W | Instruction tag |
| disp_lat | input | LAT_W | Predicted issue latency in cycles |
| disp_src_a | input | log2(NREG) | First source register |
| disp_src_b | input | log2(NREG) | Second source register |
| disp_dst | input | log2(NREG) | Destination register |
| disp_exlat | input | EX_W | Execution latency field X (dependents may issue X+1 cycles later) |
| disp_stall | output | 1 | Queue full, dispatch is dropped |
| iss_valid | output | PORTS | Per-port issue valid |
| iss_tag | output | PORTS x TAG_W | Per-port issued tag |

## Verification
The bench uses the default parameters: 8 entries, 4 ports, 16 registers and 3-bit latency fields. A few dispatches are enough to fill the queue and reach the stall boundary. Six dependents waiting on one producer give more eligible entries than ports. With eight-cycle execution countdowns, a new writer of a register can arrive while an older countdown on it is still pending. With only 16 registers, randomly chosen sources often hit registers that are still pending, so the precheck retry path is exercised frequently next to the plain countdown path.

// File: rtl/iq_pkg.sv
package iq_pkg;
  // Number of four-input levels needed to cover n requests.
  function automatic int tree_levels(input int n);
    int lv;
    int cap;
    lv  = 1;
    cap = 4;
    while (cap < n) begin
      cap = cap * 4;
      lv  = lv + 1;
    end
    return lv;
  endfunction
endpackage

// File: rtl/iq_arb_cell.sv
module iq_arb_cell (
  input  logic [3:0] req,
  input  logic       enb,
  output logic [3:0] gnt,
  output logic       any
);
  // Fixed priority: the lowest index is the oldest.
  always_comb begin
    gnt    = 4'b0000;
    gnt[0] = enb && req[0];
    gnt[1] = enb && req[1] && !req[0];
    gnt[2] = enb && req[2] && !(|req[1:0]);
    gnt[3] = enb && req[3] && !(|req[2:0]);
  end
  assign any = |req;
endmodule

// File: rtl/iq_sel_tree.sv
module iq_sel_tree
  import iq_pkg::*;
#(
  parameter int N = 8
) (
  input  logic [N-1:0] req,
  output logic [N-1:0] gnt
);
  localparam int LV = tree_levels(N);
  localparam int W  = 4 ** LV;

  logic [W-1:0] up [LV+1];
  logic [W-1:0] dn [LV+1];
  logic [W-1:0] req_pad;

  always_comb begin
    req_pad        = '0;
    req_pad[N-1:0] = req;
  end
  assign up[0]  = req_pad;
  assign dn[LV] = W'(1);

  for (genvar l = 0; l < LV; l++) begin : g_lvl
    localparam int CELLS = W >> (2 * (l + 1));
    if (l > 0 && 4 * CELLS < W) begin : g_pad_dn
      assign dn[l][W-1:4*CELLS] = '0;
    end
    if (CELLS < W) begin : g_pad_up
      assign up[l+1][W-1:CELLS] = '0;
    end
    for (genvar c = 0; c < CELLS; c++) begin : g_cell
      iq_arb_cell u_cell (
        .req (up[l][4*c +: 4]),
        .enb (dn[l+1][c]),
        .gnt (dn[l][4*c +: 4]),
        .any (up[l+1][c])
      );
    end
  end

  assign gnt = dn[0][N-1:0];
endmodule

// File: rtl/iq_ready_table.sv
module iq_ready_table #(
  parameter int  NREG  = 16,
  parameter int  PORTS = 4,
  parameter int  EX_W  = 3,
  localparam int RW    = $clog2(NREG)
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       clr_en,
  input  logic [RW-1:0]              clr_idx,
  input  logic [PORTS-1:0]           set_en,
  input  logic [PORTS-1:0][RW-1:0]   set_idx,
  input  logic [PORTS-1:0][EX_W-1:0] set_ex,
  output logic [NREG-1:0]            rdy
);
  logic [NREG-1:0] rdy_r, rdy_nx;
  logic [EX_W-1:0] cnt_r  [NREG];
  logic [EX_W-1:0] cnt_nx [NREG];

  always_comb begin
    for (int r = 0; r < NREG; r++) begin
      rdy_nx[r] = rdy_r[r];
      cnt_nx[r] = cnt_r[r];
      if (cnt_r[r] != '0) begin
        cnt_nx[r] = cnt_r[r] - 1'b1;
        if (cnt_r[r] == EX_W'(1)) rdy_nx[r] = 1'b1;
      end
      // Lower port numbers take precedence on a shared destination.
      for (int p = PORTS - 1; p >= 0; p--) begin
        if (set_en[p] && set_idx[p] == RW'(r)) begin
          if (set_ex[p] == '0) begin
            rdy_nx[r] = 1'b1;
            cnt_nx[r] = '0;
          end else begin
            cnt_nx[r] = set_ex[p];
          end
        end
      end
      // A newer writer overrides any result still in flight.
      if (clr_en && clr_idx == RW'(r)) begin
        rdy_nx[r] = 1'b0;
        cnt_nx[r] = '0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdy_r <= '1;
      for (int r = 0; r < NREG; r++) cnt_r[r] <= '0;
    end else begin
      rdy_r <= rdy_nx;
      for (int r = 0; r < NREG; r++) cnt_r[r] <= cnt_nx[r];
    end
  end

  assign rdy = rdy_r;
endmodule

// File: rtl/lat_issue_queue.sv
module lat_issue_queue #(
  parameter int  DEPTH = 8,
  parameter int  PORTS = 4,
  parameter int  NREG  = 16,
  parameter int  TAG_W = 6,
  parameter int  LAT_W = 3,
  parameter int  EX_W  = 3,
  localparam int RW    = $clog2(NREG)
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        disp_valid,
  input  logic [TAG_W-1:0]            disp_tag,
  input  logic [LAT_W-1:0]            disp_lat,
  input  logic [RW-1:0]               disp_src_a,
  input  logic [RW-1:0]               disp_src_b,
  input  logic [RW-1:0]               disp_dst,
  input  logic [EX_W-1:0]             disp_exlat,
  output logic                        disp_stall,
  output logic [PORTS-1:0]            iss_valid,
  output logic [PORTS-1:0][TAG_W-1:0] iss_tag
);
  localparam int CW = $clog2(DEPTH + 1);

  typedef struct packed {
    logic [TAG_W-1:0] tag;
    logic [LAT_W-1:0] lat;
    logic [RW-1:0]    sa;
    logic [RW-1:0]    sb;
    logic [RW-1:0]    dst;
    logic [EX_W-1:0]  ex;
  } ent_t;

  ent_t q_r  [DEPTH];
  ent_t q_nx [DEPTH];
  logic [CW-1:0] occ_r, occ_nx;

  logic [NREG-1:0]            rdy;
  logic [DEPTH-1:0]           live, req, taken;
  logic [DEPTH-1:0]           avail [PORTS+1];
  logic [DEPTH-1:0]           gnt   [PORTS];
  logic [PORTS-1:0][RW-1:0]   set_idx;
  logic [PORTS-1:0][EX_W-1:0] set_ex;
  logic                       accept;

  assign disp_stall = (occ_r == CW'(DEPTH));
  assign accept     = disp_valid && !disp_stall;

  // Countdown at zero, gated by the ready-bit precheck.
  always_comb begin
    for (int i = 0; i < DEPTH; i++) begin
      live[i] = (CW'(i) < occ_r);
      req[i]  = live[i] && (q_r[i].lat == '0) && rdy[q_r[i].sa] && rdy[q_r[i].sb];
    end
  end

  // One selection tree per port, each seeing what earlier trees left.
  assign avail[0] = req;
  for (genvar p = 0; p < PORTS; p++) begin : g_port
    iq_sel_tree #(.N(DEPTH)) u_sel (
      .req (avail[p]),
      .gnt (gnt[p])
    );
    assign avail[p+1] = avail[p] & ~gnt[p];
  end
  assign taken = req & ~avail[PORTS];

  always_comb begin
    for (int p = 0; p < PORTS; p++) begin
      iss_valid[p] = |gnt[p];
      iss_tag[p]   = '0;
      set_idx[p]   = '0;
      set_ex[p]    = '0;
      for (int i = 0; i < DEPTH; i++) begin
        if (gnt[p][i]) begin
          iss_tag[p] = iss_tag[p] | q_r[i].tag;
          set_idx[p] = set_idx[p] | q_r[i].dst;
          set_ex[p]  = set_ex[p]  | q_r[i].ex;
        end
      end
    end
  end

  // Collapse survivors towards slot 0, counting down, then append.
  always_comb begin
    int pos;
    for (int i = 0; i < DEPTH; i++) q_nx[i] = q_r[i];
    pos = 0;
    for (int i = 0; i < DEPTH; i++) begin
      if (live[i] && !taken[i]) begin
        q_nx[pos] = q_r[i];
        if (q_r[i].lat != '0) q_nx[pos].lat = q_r[i].lat - 1'b1;
        pos = pos + 1;
      end
    end
    if (accept && pos < DEPTH) begin
      q_nx[pos].tag = disp_tag;
      q_nx[pos].lat = disp_lat;
      q_nx[pos].sa  = disp_src_a;
      q_nx[pos].sb  = disp_src_b;
      q_nx[pos].dst = disp_dst;
      q_nx[pos].ex  = disp_exlat;
    end
    occ_nx = CW'(pos) + CW'(accept);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) occ_r <= '0;
    else        occ_r <= occ_nx;
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < DEPTH; i++) q_r[i] <= q_nx[i];
  end

  iq_ready_table #(.NREG(NREG), .PORTS(PORTS), .EX_W(EX_W)) u_rdy (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr_en  (accept),
    .clr_idx (disp_dst),
    .set_en  (iss_valid),
    .set_idx (set_idx),
    .set_ex  (set_ex),
    .rdy     (rdy)
  );
endmodule

// File: rtl/iq_checker.sv
module iq_checker #(
  parameter int  DEPTH = 8,
  parameter int  PORTS = 4,
  localparam int CW    = $clog2(DEPTH + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             disp_valid,
  input logic             disp_stall,
  input logic [PORTS-1:0] iss_valid,
  input logic [CW-1:0]    occ
);
  AST_EMPTY_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    occ == '0 |-> (iss_valid == '0) && !disp_stall);  // R1
  AST_ISSUE_CAP: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(iss_valid) <= int'(occ));  // R4
  AST_PORTS_PACKED: assert property (@(posedge clk) disable iff (!rst_n)
    ((iss_valid + 1'b1) & iss_valid) == '0);  // R5
  AST_OCC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> int'(occ) == int'($past(occ)) - $countones($past(iss_valid))
                                  + int'($past(disp_valid && !disp_stall)));  // R6
  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    disp_stall && iss_valid == '0 |=> disp_stall);  // R7
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    int'(occ) <= DEPTH);  // R7
endmodule

bind lat_issue_queue iq_checker #(.DEPTH(DEPTH), .PORTS(PORTS)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .disp_valid (disp_valid),
  .disp_stall (disp_stall),
  .iss_valid  (iss_valid),
  .occ        (occ_r)
);

// File: tb/tb_lat_issue_queue.sv
module tb_lat_issue_queue;
  localparam int DEPTH = 8;
  localparam int PORTS = 4;
  localparam int NREG  = 16;
  localparam int TAG_W = 6;

  logic clk = 1'b0;
  logic rst_n;
  logic dv;
  logic [TAG_W-1:0] dtag;
  logic [2:0] dlat, dex;
  logic [3:0] dsa, dsb, ddst;
  logic stall;
  logic [PORTS-1:0] ivalid;
  logic [PORTS-1:0][TAG_W-1:0] itag;

  always #5 clk = ~clk;

  lat_issue_queue dut (
    .clk(clk), .rst_n(rst_n), .disp_valid(dv), .disp_tag(dtag), .disp_lat(dlat),
    .disp_src_a(dsa), .disp_src_b(dsb), .disp_dst(ddst), .disp_exlat(dex),
    .disp_stall(stall), .iss_valid(ivalid), .iss_tag(itag)
  );

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  // Reference model state
  int mq_tag [DEPTH];
  int mq_lat [DEPTH];
  int mq_sa  [DEPTH];
  int mq_sb  [DEPTH];
  int mq_dst [DEPTH];
  int mq_ex  [DEPTH];
  int mqn;
  bit mrdy [NREG];
  int mpend [NREG];

  function automatic bit elig(int i);
    return mq_lat[i] == 0 && mrdy[mq_sa[i]] && mrdy[mq_sb[i]];
  endfunction

  task automatic fail_line(string req, string what, int act, int exp);
    errors++;
    $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
  endtask

  task automatic drive(bit v, int tag, int lat, int sa, int sb, int dst, int ex);
    dv = v; dtag = TAG_W'(tag); dlat = 3'(lat); dsa = 4'(sa); dsb = 4'(sb);
    ddst = 4'(dst); dex = 3'(ex);
  endtask

  task automatic step(string lbl);
    int gi [PORTS];
    int ng;
    bit acc;
    int nq_tag [DEPTH]; int nq_lat [DEPTH]; int nq_sa [DEPTH];
    int nq_sb [DEPTH];  int nq_dst [DEPTH]; int nq_ex [DEPTH];
    int nn;
    bit gone [DEPTH];
    #1;
    ng = 0;
    for (int i = 0; i < DEPTH; i++) gone[i] = 0;
    for (int i = 0; i < mqn; i++) begin
      if (ng < PORTS && elig(i)) begin gi[ng] = i; gone[i] = 1; ng++; end
    end
    checks++;
    if (stall !== (mqn == DEPTH)) fail_line(lbl, "stall", int'(stall), int'(mqn == DEPTH));
    for (int p = 0; p < PORTS; p++) begin
      checks++;
      if (ivalid[p] !== (p < ng)) fail_line(lbl, $sformatf("valid port%0d", p), int'(ivalid[p]), int'(p < ng));
      else if (p < ng && int'(itag[p]) != mq_tag[gi[p]])
        fail_line(lbl, $sformatf("tag port%0d", p), int'(itag[p]), mq_tag[gi[p]]);
    end
    // model update: ready table
    acc = dv && (mqn != DEPTH);
    for (int r = 0; r < NREG; r++) begin
      if (mpend[r] != 0) begin mpend[r]--; if (mpend[r] == 0) mrdy[r] = 1; end
    end
    for (int p = ng - 1; p >= 0; p--) begin
      if (mq_ex[gi[p]] == 0) begin mrdy[mq_dst[gi[p]]] = 1; mpend[mq_dst[gi[p]]] = 0; end
      else mpend[mq_dst[gi[p]]] = mq_ex[gi[p]];
    end
    if (acc) begin mrdy[ddst] = 0; mpend[ddst] = 0; end
    // model update: queue
    nn = 0;
    for (int i = 0; i < mqn; i++) begin
      if (!gone[i]) begin
        nq_tag[nn] = mq_tag[i]; nq_lat[nn] = (mq_lat[i] > 0) ? mq_lat[i] - 1 : 0;
        nq_sa[nn] = mq_sa[i]; nq_sb[nn] = mq_sb[i]; nq_dst[nn] = mq_dst[i]; nq_ex[nn] = mq_ex[i];
        nn++;
      end
    end
    if (acc) begin
      nq_tag[nn] = int'(dtag); nq_lat[nn] = int'(dlat); nq_sa[nn] = int'(dsa);
      nq_sb[nn] = int'(dsb); nq_dst[nn] = int'(ddst); nq_ex[nn] = int'(dex);
      nn++;
    end
    for (int i = 0; i < nn; i++) begin
      mq_tag[i] = nq_tag[i]; mq_lat[i] = nq_lat[i]; mq_sa[i] = nq_sa[i];
      mq_sb[i] = nq_sb[i]; mq_dst[i] = nq_dst[i]; mq_ex[i] = nq_ex[i];
    end
    mqn = nn;
    @(negedge clk);
  endtask

  task automatic idle(int n, string lbl);
    for (int k = 0; k < n; k++) begin drive(0, 0, 0, 0, 0, 0, 0); step(lbl); end
  endtask

  function automatic bit reg_busy(int r);
    if (!mrdy[r] || mpend[r] != 0) return 1;
    for (int i = 0; i < mqn; i++)
      if (mq_dst[i] == r || mq_sa[i] == r || mq_sb[i] == r) return 1;
    return 0;
  endfunction

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int seed;
    int sa, sb, dst, start;
    seed = $urandom(32'h5eed_1234);
    rst_n = 1'b0;
    drive(0, 0, 0, 0, 0, 0, 0);
    mqn = 0;
    for (int r = 0; r < NREG; r++) begin mrdy[r] = 1; mpend[r] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: idle after reset
    #1;
    checks++;
    if (ivalid !== '0) fail_line("R1", "valid", int'(ivalid), 0);
    checks++;
    if (stall !== 1'b0) fail_line("R1", "stall", int'(stall), 0);
    @(negedge clk);
    idle(2, "R1");

    // R2: predicted latency 3, sources ready
    drive(1, 1, 3, 0, 1, 8, 0); step("R2");
    idle(5, "R2");

    // R8 and R3: producer with X=3, dependent waits at zero
    drive(1, 2, 0, 0, 1, 9, 3);  step("R8");
    drive(1, 3, 0, 9, 2, 10, 0); step("R3");
    idle(7, "R3");

    // R4: six dependents released together by one producer
    drive(1, 4, 0, 0, 1, 11, 6); step("R4");
    for (int k = 0; k < 6; k++) begin
      drive(1, 5 + k, 0, 11, 0, (k < 4) ? 12 + k : k - 2, 0); step("R4");
    end
    idle(10, "R4");

    // R6: younger eligible entry bypasses an older waiting one
    drive(1, 12, 5, 0, 1, 6, 0); step("R6");
    drive(1, 13, 0, 0, 1, 7, 0); step("R6");
    idle(8, "R6");

    // R7: fill the queue behind a long producer, then a dropped dispatch
    drive(1, 20, 0, 0, 1, 5, 7); step("R7");
    for (int k = 0; k < 8; k++) begin
      drive(1, 21 + k, 0, 5, 0, (k < 5) ? 6 + k : 7 + k, 0); step("R7");
    end
    drive(1, 30, 0, 0, 1, 1, 0); step("R7");
    idle(12, "R7");

    // R9: a new writer cancels a pending countdown on the same register
    drive(1, 40, 0, 0, 1, 4, 5); step("R9");
    drive(1, 41, 6, 0, 1, 4, 0); step("R9");
    drive(1, 42, 0, 4, 0, 3, 0); step("R9");
    idle(14, "R9");

    // Random traffic: R4, R5, R6
    for (int n = 0; n < 600; n++) begin
      if (($urandom % 10) < 7) begin
        sa = $urandom % NREG;
        sb = $urandom % NREG;
        dst = -1;
        start = $urandom % NREG;
        for (int k = 0; k < NREG; k++) begin
          int r;
          r = (start + k) % NREG;
          if (dst < 0 && r != sa && r != sb && !reg_busy(r)) dst = r;
        end
        if (dst >= 0) drive(1, 100 + n, $urandom % 8, sa, sb, dst, $urandom % 8);
        else drive(0, 0, 0, 0, 0, 0, 0);
      end else begin
        drive(0, 0, 0, 0, 0, 0, 0);
      end
      step("R4,R5,R6");
    end
    idle(40, "R5");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule